// File: doc/BRIEF.md
# Write Issue Credit and ID Allocator

This block sits between the cores of a multi-core cluster and the cluster's coherent AXI-style master port. It decides which write may go out on that port. Each core presents at most one pending request at a time. A request carries a barrier flag and a two-bit memory kind. A request is granted only when the pool that covers its class has room. A granted request always receives an AXI write ID, and one request is granted per cycle. When a write response comes back, its ID returns on the completion input. That response frees the credit and, once no other write holds the ID, frees the ID as well.

The block keeps two credit pools. Ordinary writes share a pool of WR_SLOTS credits, and non-write-back kinds may use one fewer than that. Barriers draw on a separate set of slots: one private slot per core and one spare slot for the whole cluster. A single write and a burst each cost exactly one credit. A request that cannot be granted stays pending with valid asserted until room appears. Strongly ordered device writes may all share one ID. Every other write gets an ID that no other outstanding transaction holds.

Top module: `wr_issue_alloc`

## Requirements
- R1: After reset no grant is given while no request is valid, and the first write-back write is given ID 0.
- R2: Memory kind 2'b00 (normal, inner and outer write-back) can fill all WR_SLOTS write credits (16 by default). One more non-barrier write is held while they are all in use.
- R3: Kinds 2'b01 (normal non-cacheable or write-through), 2'b10 and 2'b11 (device) together hold at most WR_SLOTS-1 credits. A write-back write can still take the last credit while a request of another kind waits.
- R4: A request that cannot be granted is not dropped. It is granted once a completion frees the credit it needs.
- R5: A write that does not share an ID takes the lowest-numbered free ID in 0..WR_SLOTS-1.
- R6: Kind 2'b10 (strongly ordered device) reuses the ID of an outstanding kind-2'b10 group when one exists. That ID becomes free only after as many completions as it had grants.
- R7: A barrier from core c takes ID WR_SLOTS+c when that core's slot is free. Otherwise it takes the cluster slot ID WR_SLOTS+N_CORES. It is held when both are busy.
- R8: Barriers use no write credits. A barrier is granted even while all WR_SLOTS write credits are in use.
- R9: Grants rotate round-robin over the requesters that can be granted. After core c is granted, the search starts at core c+1. A core that cannot be granted does not stop other cores.
- R10: A completion carrying an ID that is not outstanding, or that is out of range, has no effect.
- R11: At most one grant is given per cycle, and only to a core whose request is valid. The grant is the one-hot vector gnt in the same cycle as the request, and it comes with gnt_id.
- R12: A credit freed by a completion can be granted from the next cycle on, not in the cycle of the completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_CORES | Per-core request pending |
| req_bar | input | N_CORES | Per-core request is a barrier |
| req_kind | input | 2*N_CORES | Per-core memory kind, core c at bits [2c+1:2c] |
| cpl_valid | input | 1 | A write response is returning |
| cpl_id | input | ID_W | ID carried by the returning response |
| gnt | output | N_CORES | One-hot grant, same cycle as the request |
| gnt_id | output | ID_W | ID given to the granted request |

## Verification
Single-kind floods separate the full-pool limit from the reduced limit for the other kinds. A write-back request arriving behind a blocked non-write-back request shows that the limits are judged per class and that a blocked core does not stall the rotation. Interleaved strongly ordered and unique device writes, with partial completions, distinguish the count kept on a shared ID from simple set-and-clear of an ID. Repeated barriers from one core show when the per-core slot and the cluster slot are used. A long mixed run with random completions, some of them for IDs that are not outstanding, is compared against the reference model on every cycle.

// File: rtl/wia_pkg.sv
package wia_pkg;

    typedef enum logic [1:0] {
        MK_WB      = 2'b00,
        MK_NC_WT   = 2'b01,
        MK_DEV_ORD = 2'b10,
        MK_DEV_REL = 2'b11
    } mem_kind_e;

    typedef struct packed {
        logic      is_bar;
        mem_kind_e kind;
    } wr_req_t;

    function automatic logic kind_uses_full_pool(mem_kind_e k);
        return k == MK_WB;
    endfunction

    function automatic logic kind_shares_id(mem_kind_e k);
        return k == MK_DEV_ORD;
    endfunction

endpackage

// File: rtl/wia_rr_arb.sv
module wia_rr_arb #(
    parameter int N  = 4,
    parameter int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  elig,
    output logic [N-1:0]  gnt,
    output logic          win_valid,
    output logic [PW-1:0] win_idx
);
    logic [PW-1:0] ptr_q;

    always_comb begin
        int idx;
        gnt       = '0;
        win_valid = 1'b0;
        win_idx   = '0;
        for (int i = 0; i < N; i++) begin
            idx = (int'(ptr_q) + i) % N;
            if (!win_valid && elig[idx]) begin
                gnt[idx]  = 1'b1;
                win_valid = 1'b1;
                win_idx   = PW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (win_valid) begin
            ptr_q <= (int'(win_idx) == N - 1) ? '0 : win_idx + 1'b1;
        end
    end
endmodule

// File: rtl/wia_credit.sv
module wia_credit #(
    parameter int WR_SLOTS = 16,
    parameter int CNT_W    = $clog2(WR_SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             take_wb,
    input  logic             give,
    input  logic             give_wb,
    output logic             wb_ok,
    output logic             oth_ok,
    output logic [CNT_W-1:0] total,
    output logic [CNT_W-1:0] other
);
    localparam int OTH_SLOTS = WR_SLOTS - 1;

    logic [CNT_W-1:0] total_d, other_d;

    assign wb_ok  = int'(total) < WR_SLOTS;
    assign oth_ok = wb_ok && (int'(other) < OTH_SLOTS);

    always_comb begin
        total_d = total + CNT_W'(take) - CNT_W'(give);
        other_d = other + CNT_W'(take && !take_wb) - CNT_W'(give && !give_wb);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            total <= '0;
            other <= '0;
        end else begin
            total <= total_d;
            other <= other_d;
        end
    end
endmodule

// File: rtl/wia_id_pool.sv
module wia_id_pool #(
    parameter int WR_SLOTS = 16,
    parameter int ID_W     = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            alloc,
    input  logic            alloc_wb,
    input  logic            alloc_share,
    input  logic            rel_valid,
    input  logic [ID_W-1:0] rel_id,
    output logic [ID_W-1:0] pick_id,
    output logic            id_avail,
    output logic            share_live,
    output logic            rel_hit,
    output logic            rel_wb
);
    localparam int IX_W  = (WR_SLOTS > 1) ? $clog2(WR_SLOTS) : 1;
    localparam int CNT_W = $clog2(WR_SLOTS + 1);

    logic [WR_SLOTS-1:0] busy_q, busy_d, wb_q, wb_d;
    logic [IX_W-1:0]     low_ix, sh_ix_q, sh_ix_d, rel_ix;
    logic [CNT_W-1:0]    sh_cnt_q, sh_cnt_d;
    logic                any_free, rel_on_share, sh_inc, sh_dec, reuse;

    // lowest free ID, searched from the top so the last hit wins
    always_comb begin
        low_ix   = '0;
        any_free = 1'b0;
        for (int i = WR_SLOTS - 1; i >= 0; i--) begin
            if (!busy_q[i]) begin
                low_ix   = IX_W'(i);
                any_free = 1'b1;
            end
        end
    end

    assign rel_ix       = rel_id[IX_W-1:0];
    assign share_live   = sh_cnt_q != '0;
    assign reuse        = alloc_share && share_live;
    assign pick_id      = reuse ? ID_W'(sh_ix_q) : ID_W'(low_ix);
    assign id_avail     = any_free;
    assign rel_hit      = rel_valid && (int'(rel_id) < WR_SLOTS) && busy_q[rel_ix];
    assign rel_wb       = wb_q[rel_ix];
    assign rel_on_share = share_live && (rel_ix == sh_ix_q);

    always_comb begin
        busy_d  = busy_q;
        wb_d    = wb_q;
        sh_ix_d = sh_ix_q;
        sh_inc  = alloc && alloc_share;
        sh_dec  = rel_hit && rel_on_share;

        if (rel_hit && !rel_on_share) begin
            busy_d[rel_ix] = 1'b0;
        end
        if (alloc && !reuse) begin
            busy_d[low_ix] = 1'b1;
            wb_d[low_ix]   = alloc_wb;
            if (alloc_share) begin
                sh_ix_d = low_ix;
            end
        end

        sh_cnt_d = sh_cnt_q + CNT_W'(sh_inc) - CNT_W'(sh_dec);
        if (sh_dec && sh_cnt_d == '0) begin
            busy_d[sh_ix_q] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= '0;
            wb_q     <= '0;
            sh_ix_q  <= '0;
            sh_cnt_q <= '0;
        end else begin
            busy_q   <= busy_d;
            wb_q     <= wb_d;
            sh_ix_q  <= sh_ix_d;
            sh_cnt_q <= sh_cnt_d;
        end
    end
endmodule

// File: rtl/wia_bar_slots.sv
module wia_bar_slots #(
    parameter int N_CORES  = 4,
    parameter int WR_SLOTS = 16,
    parameter int ID_W     = 5,
    parameter int PW       = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               alloc,
    input  logic [PW-1:0]      alloc_core,
    input  logic               rel_valid,
    input  logic [ID_W-1:0]    rel_id,
    output logic [N_CORES-1:0] core_ok,
    output logic [ID_W-1:0]    alloc_id
);
    localparam int CLUS_ID = WR_SLOTS + N_CORES;

    logic [N_CORES-1:0] own_q, own_d;
    logic               clus_q, clus_d;

    generate
        for (genvar c = 0; c < N_CORES; c++) begin : g_ok
            assign core_ok[c] = !own_q[c] || !clus_q;
        end
    endgenerate

    assign alloc_id = own_q[alloc_core] ? ID_W'(CLUS_ID)
                                        : ID_W'(WR_SLOTS + int'(alloc_core));

    always_comb begin
        own_d  = own_q;
        clus_d = clus_q;
        if (rel_valid) begin
            for (int c = 0; c < N_CORES; c++) begin
                if (int'(rel_id) == WR_SLOTS + c) begin
                    own_d[c] = 1'b0;
                end
            end
            if (int'(rel_id) == CLUS_ID) begin
                clus_d = 1'b0;
            end
        end
        if (alloc) begin
            if (own_q[alloc_core]) begin
                clus_d = 1'b1;
            end else begin
                own_d[alloc_core] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q  <= '0;
            clus_q <= 1'b0;
        end else begin
            own_q  <= own_d;
            clus_q <= clus_d;
        end
    end
endmodule

// File: rtl/wr_issue_alloc.sv
module wr_issue_alloc
    import wia_pkg::*;
#(
    parameter int N_CORES  = 4,
    parameter int WR_SLOTS = 16,
    localparam int NUM_IDS = WR_SLOTS + N_CORES + 1,
    localparam int ID_W    = $clog2(NUM_IDS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_CORES-1:0]   req_valid,
    input  logic [N_CORES-1:0]   req_bar,
    input  logic [2*N_CORES-1:0] req_kind,
    input  logic                 cpl_valid,
    input  logic [ID_W-1:0]      cpl_id,
    output logic [N_CORES-1:0]   gnt,
    output logic [ID_W-1:0]      gnt_id
);
    localparam int PW    = (N_CORES > 1) ? $clog2(N_CORES) : 1;
    localparam int CNT_W = $clog2(WR_SLOTS + 1);

    wr_req_t            req   [N_CORES];
    logic [N_CORES-1:0] elig, bar_ok;
    logic               wb_ok, oth_ok, id_avail, share_live;
    logic               win_valid, rel_hit, rel_wb;
    logic [PW-1:0]      win_idx;
    wr_req_t            win_req;
    logic [ID_W-1:0]    pool_id, bar_id;
    logic [CNT_W-1:0]   cr_total, cr_other;
    logic               wr_alloc, bar_alloc;

    generate
        for (genvar c = 0; c < N_CORES; c++) begin : g_core
            always_comb begin
                req[c].is_bar = req_bar[c];
                req[c].kind   = mem_kind_e'(req_kind[2*c +: 2]);
                if (req[c].is_bar) begin
                    elig[c] = req_valid[c] && bar_ok[c];
                end else begin
                    elig[c] = req_valid[c]
                           && (kind_uses_full_pool(req[c].kind) ? wb_ok : oth_ok)
                           && (id_avail || (kind_shares_id(req[c].kind) && share_live));
                end
            end
        end
    endgenerate

    wia_rr_arb #(.N(N_CORES), .PW(PW)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .elig      (elig),
        .gnt       (gnt),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    assign win_req   = req[win_idx];
    assign wr_alloc  = win_valid && !win_req.is_bar;
    assign bar_alloc = win_valid && win_req.is_bar;
    assign gnt_id    = win_req.is_bar ? bar_id : pool_id;

    wia_credit #(.WR_SLOTS(WR_SLOTS), .CNT_W(CNT_W)) u_cred (
        .clk     (clk),
        .rst     (rst),
        .take    (wr_alloc),
        .take_wb (kind_uses_full_pool(win_req.kind)),
        .give    (rel_hit),
        .give_wb (rel_wb),
        .wb_ok   (wb_ok),
        .oth_ok  (oth_ok),
        .total   (cr_total),
        .other   (cr_other)
    );

    wia_id_pool #(.WR_SLOTS(WR_SLOTS), .ID_W(ID_W)) u_ids (
        .clk         (clk),
        .rst         (rst),
        .alloc       (wr_alloc),
        .alloc_wb    (kind_uses_full_pool(win_req.kind)),
        .alloc_share (kind_shares_id(win_req.kind)),
        .rel_valid   (cpl_valid),
        .rel_id      (cpl_id),
        .pick_id     (pool_id),
        .id_avail    (id_avail),
        .share_live  (share_live),
        .rel_hit     (rel_hit),
        .rel_wb      (rel_wb)
    );

    wia_bar_slots #(.N_CORES(N_CORES), .WR_SLOTS(WR_SLOTS), .ID_W(ID_W), .PW(PW)) u_bar (
        .clk        (clk),
        .rst        (rst),
        .alloc      (bar_alloc),
        .alloc_core (win_idx),
        .rel_valid  (cpl_valid),
        .rel_id     (cpl_id),
        .core_ok    (bar_ok),
        .alloc_id   (bar_id)
    );
endmodule

// File: rtl/wia_chk.sv
module wia_chk #(
    parameter int N_CORES  = 4,
    parameter int WR_SLOTS = 16,
    parameter int ID_W     = 5,
    parameter int CNT_W    = 5
) (
    input logic               clk,
    input logic               rst,
    input logic [N_CORES-1:0] req_valid,
    input logic [N_CORES-1:0] req_bar,
    input logic [N_CORES-1:0] gnt,
    input logic [ID_W-1:0]    gnt_id,
    input logic               cpl_valid,
    input logic [ID_W-1:0]    cpl_id,
    input logic [CNT_W-1:0]   cr_total,
    input logic [CNT_W-1:0]   cr_other
);
    localparam int NUM_IDS = WR_SLOTS + N_CORES + 1;

    a_r11_one_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    a_r11_grant_valid: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req_valid) == '0);

    a_r2_total_cap: assert property (@(posedge clk) disable iff (rst)
        int'(cr_total) <= WR_SLOTS);

    a_r3_other_cap: assert property (@(posedge clk) disable iff (rst)
        int'(cr_other) <= WR_SLOTS - 1);

    a_r5_write_id_range: assert property (@(posedge clk) disable iff (rst)
        |(gnt & ~req_bar) |-> int'(gnt_id) < WR_SLOTS);

    a_r7_bar_id_range: assert property (@(posedge clk) disable iff (rst)
        |(gnt & req_bar) |-> (int'(gnt_id) >= WR_SLOTS && int'(gnt_id) < NUM_IDS));

    a_r10_stray_cpl: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && int'(cpl_id) >= NUM_IDS && gnt == '0) |=> $stable(cr_total));
endmodule

bind wr_issue_alloc wia_chk #(
    .N_CORES  (N_CORES),
    .WR_SLOTS (WR_SLOTS),
    .ID_W     (ID_W),
    .CNT_W    (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_bar   (req_bar),
    .gnt       (gnt),
    .gnt_id    (gnt_id),
    .cpl_valid (cpl_valid),
    .cpl_id    (cpl_id),
    .cr_total  (cr_total),
    .cr_other  (cr_other)
);

// File: tb/sim_wr_issue_alloc.sv
`timescale 1ns/100ps
module sim_wr_issue_alloc;
    localparam int NC   = 4;
    localparam int WS   = 16;
    localparam int NIDS = WS + NC + 1;
    localparam int IW   = $clog2(NIDS);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [NC-1:0]   req_valid = '0;
    logic [NC-1:0]   req_bar   = '0;
    logic [2*NC-1:0] req_kind  = '0;
    logic            cpl_valid = 1'b0;
    logic [IW-1:0]   cpl_id    = '0;
    logic [NC-1:0]   gnt;
    logic [IW-1:0]   gnt_id;

    wr_issue_alloc #(.N_CORES(NC), .WR_SLOTS(WS)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_bar(req_bar),
        .req_kind(req_kind), .cpl_valid(cpl_valid), .cpl_id(cpl_id),
        .gnt(gnt), .gnt_id(gnt_id)
    );

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R1";

    // pending requests per core: bit2 = barrier, bits1:0 = kind
    int pq[NC][$];
    // reference model state
    int idcnt[WS];
    bit idwb[WS];
    int devid = -1;
    bit barc[NC];
    bit barcl = 1'b0;
    int rrptr = 0;
    bit nxt_cv = 1'b0;
    int nxt_ci = 0;
    int dut_gnt, dut_id;

    task automatic chk(bit ok, string t, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", t, what, act, exp, $time);
        end
    endtask

    function automatic int m_tot();
        int s = 0;
        for (int i = 0; i < WS; i++) s += idcnt[i];
        return s;
    endfunction

    function automatic int m_oth();
        int s = 0;
        for (int i = 0; i < WS; i++) if (!idwb[i]) s += idcnt[i];
        return s;
    endfunction

    function automatic bit m_elig(int r, int c);
        if (r[2]) return !barc[c] || !barcl;
        if (r[1:0] == 0) return m_tot() < WS;
        return m_tot() < WS && m_oth() < WS - 1;
    endfunction

    function automatic int m_low();
        for (int i = 0; i < WS; i++) if (idcnt[i] == 0) return i;
        return -1;
    endfunction

    task automatic step();
        int w, eid, r, expv;
        for (int c = 0; c < NC; c++) begin
            req_valid[c] = pq[c].size() > 0;
            r = (pq[c].size() > 0) ? pq[c][0] : 0;
            req_bar[c] = r[2];
            req_kind[2*c +: 2] = r[1:0];
        end
        cpl_valid = nxt_cv;
        cpl_id    = IW'(nxt_ci);
        #1;
        w = -1; eid = 0;
        for (int i = 0; i < NC; i++) begin
            int c = (rrptr + i) % NC;
            if (w < 0 && pq[c].size() > 0 && m_elig(pq[c][0], c)) w = c;
        end
        if (w >= 0) begin
            r = pq[w][0];
            if (r[2]) eid = barc[w] ? WS + NC : WS + w;
            else if (r[1:0] == 2 && devid >= 0) eid = devid;
            else eid = m_low();
        end
        expv = (w >= 0) ? (1 << w) : 0;
        dut_gnt = int'(gnt);
        dut_id  = int'(gnt_id);
        chk(dut_gnt == expv, tag, "grant vector", dut_gnt, expv);
        if (w >= 0) chk(dut_id == eid, tag, "grant id", dut_id, eid);
        // completion applies to state seen before this cycle's grant
        if (nxt_cv) begin
            if (nxt_ci < WS && idcnt[nxt_ci] > 0) begin
                idcnt[nxt_ci]--;
                if (idcnt[nxt_ci] == 0 && nxt_ci == devid) devid = -1;
            end else if (nxt_ci >= WS && nxt_ci < WS + NC) begin
                barc[nxt_ci - WS] = 1'b0;
            end else if (nxt_ci == WS + NC) begin
                barcl = 1'b0;
            end
        end
        if (w >= 0) begin
            if (r[2]) begin
                if (eid == WS + NC) barcl = 1'b1; else barc[w] = 1'b1;
            end else begin
                idcnt[eid]++;
                idwb[eid] = (r[1:0] == 0);
                if (r[1:0] == 2) devid = eid;
            end
            rrptr = (w + 1) % NC;
            void'(pq[w].pop_front());
        end
        nxt_cv = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic push(int c, bit bar, int kind);
        pq[c].push_back((int'(bar) << 2) | kind);
    endtask

    task automatic cpl(int id);
        nxt_cv = 1'b1;
        nxt_ci = id;
    endtask

    function automatic int first_out();
        for (int i = 0; i < WS; i++) if (idcnt[i] > 0) return i;
        for (int c = 0; c < NC; c++) if (barc[c]) return WS + c;
        if (barcl) return WS + NC;
        return -1;
    endfunction

    task automatic drain();
        for (int k = 0; k < 400; k++) begin
            int f = first_out();
            if (f < 0 && pq[0].size() + pq[1].size() + pq[2].size() + pq[3].size() == 0) break;
            if (f >= 0) cpl(f);
            step();
        end
        run(2);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < WS; i++) begin idcnt[i] = 0; idwb[i] = 1'b0; end
        for (int c = 0; c < NC; c++) barc[c] = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: idle after reset, then first write-back gets ID 0
        tag = "R1";
        run(2);
        chk(dut_gnt == 0, "R1", "idle grant", dut_gnt, 0);
        push(0, 0, 0);
        step();
        chk(dut_id == 0, "R1", "first id", dut_id, 0);

        // R2: fill all write credits with write-back, one more held
        tag = "R2";
        for (int i = 0; i < WS; i++) push(0, 0, 0);
        run(WS + 3);
        chk(dut_gnt == 0, "R2", "17th write held", dut_gnt, 0);
        chk(pq[0].size() == 1, "R2", "pending count", pq[0].size(), 1);

        // R12 then R4/R5: free ID 5, grant only from the next cycle
        tag = "R12";
        cpl(5);
        step();
        chk(dut_gnt == 0, "R12", "no grant in completion cycle", dut_gnt, 0);
        tag = "R4";
        step();
        chk(dut_gnt == 1, "R4", "held request granted", dut_gnt, 1);
        chk(dut_id == 5, "R5", "lowest free id", dut_id, 5);

        // R8 and R7: barriers while write credits are full
        tag = "R8";
        push(2, 1, 0);
        step();
        chk(dut_id == WS + 2, "R8", "barrier with full credits", dut_id, WS + 2);
        tag = "R7";
        push(2, 1, 0);
        step();
        chk(dut_id == WS + NC, "R7", "cluster barrier slot", dut_id, WS + NC);
        push(2, 1, 0);
        step();
        chk(dut_gnt == 0, "R7", "third barrier held", dut_gnt, 0);
        cpl(WS + 2);
        run(2);
        chk(dut_id == WS + 2, "R7", "core slot reused", dut_id, WS + 2);
        tag = "R4";
        drain();

        // R3: non-write-back limited, write-back takes the last credit
        tag = "R3";
        for (int i = 0; i < WS; i++) push(0, 0, 1);
        run(WS + 2);
        chk(pq[0].size() == 1, "R3", "other kinds capped", pq[0].size(), 1);
        tag = "R9";
        push(1, 0, 0);
        step();
        chk(dut_gnt == 2, "R9", "blocked core skipped", dut_gnt, 2);
        chk(dut_id == WS - 1, "R3", "write-back takes last credit", dut_id, WS - 1);
        tag = "R3";
        drain();

        // R6: shared device IDs with partial completions
        tag = "R6";
        push(1, 0, 2); push(3, 0, 2); push(0, 0, 3); push(1, 0, 2);
        run(5);
        cpl(devid); step();
        cpl(devid); step();
        push(2, 0, 3);
        step();
        chk(dut_id != 0 || devid != 0, "R6", "shared id still held", dut_id, -1);
        cpl(devid); step();
        push(2, 0, 0);
        run(2);
        drain();

        // R10: stray completions
        tag = "R10";
        cpl(9); step();
        cpl(WS + 3); step();
        cpl(NIDS + 2); step();
        push(1, 0, 0);
        step();
        chk(dut_id == 0, "R10", "state unchanged by stray ids", dut_id, 0);
        drain();

        // R9/R11: all cores compete
        tag = "R9";
        for (int c = 0; c < NC; c++) begin push(c, 0, 0); push(c, 0, 1); end
        run(10);
        drain();

        // mixed random traffic
        tag = "R11";
        for (int k = 0; k < 1500; k++) begin
            int c = $urandom_range(NC - 1);
            if (pq[c].size() < 3 && $urandom_range(2) != 0)
                push(c, ($urandom_range(7) == 0), $urandom_range(3));
            if ($urandom_range(2) != 0) cpl($urandom_range(NIDS + 1));
            step();
        end
        drain();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule